// File: doc/BRIEF.md
# Bunch-Train Hit Frame Recorder

This block captures the trigger pattern of a multi-channel front end while a bunch train is running and sends it out afterwards. Every channel gives two discriminator bits, a low-threshold bit and a high-threshold bit. A bunch-crossing counter runs during the train and stamps each stored record. On any bunch tick where at least one of the trigger bits is set, the whole pattern of every channel is stored as one frame. Each frame holds a fixed marker byte, the crossing count and a 2-bit code per channel.

When the train-active input goes low, the block enters its readout mode. It sends the stored frames one bit per shift strobe on a single serial line, oldest frame first. After the last bit of the last frame it gives a one-cycle completion pulse and empties the store. Acquisition and readout never overlap. Raising train-active again discards anything still unread and starts a fresh record.

Top module: `hit_frame_store`

## Requirements
- R1: The crossing count is zero whenever train_active is low. During a train it advances by one, modulo 2^TS_W, on every cycle where bunch_tick is high, and the value before the advance stamps any frame written on that tick.
- R2: A frame is written only on a cycle with train_active and bunch_tick both high and at least one of the 2*NCH trigger bits set. Trigger bits without bunch_tick, or a tick with no trigger bit set, store nothing.
- R3: Frame layout, from bit FW-1 down to bit 0: the HDR_W-bit marker HDR_MARK (default 8'hA5), then the TS_W-bit crossing count, then the channel codes. Channel c occupies bits 2c+1 (trig_hi[c]) and 2c (trig_lo[c]).
- R4: Once DEPTH frames are held, mem_full is high and further triggers during the train are ignored. The first DEPTH frames are the ones read out.
- R5: With train_active low and at least one frame stored, each shift_tick sends one frame bit. ser_valid is high for one cycle in the cycle after the strobe, with the bit on ser_out, and each frame is sent from bit FW-1 down to bit 0.
- R6: Frames are sent in the order they were written, and exactly FW bits are sent per stored frame.
- R7: readout_done is a one-cycle pulse in the cycle right after the last valid bit. In that cycle the store is empty, so mem_full is low and no further bits follow.
- R8: With no frame stored, shift strobes produce no ser_valid and no readout_done.
- R9: A rising train_active discards unread frames and resets the readout position, so the next readout starts with the new train's first frame at bit FW-1.
- R10: shift_tick has no effect while train_active is high: ser_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_active | input | 1 | High: acquisition mode; low: readout mode |
| bunch_tick | input | 1 | One-cycle strobe per bunch crossing |
| trig_lo | input | NCH | Low-threshold discriminator bit per channel |
| trig_hi | input | NCH | High-threshold discriminator bit per channel |
| shift_tick | input | 1 | One-cycle strobe per serial bit in readout |
| ser_out | output | 1 | Serial frame data, valid with ser_valid |
| ser_valid | output | 1 | Marks the cycle holding a new serial bit |
| readout_done | output | 1 | One-cycle pulse after the final stored bit |
| mem_full | output | 1 | All DEPTH frame slots are occupied |

## Verification
Several properties are checked on every cycle: the crossing count steps by exactly one per tick inside a train, a full store stays full for the rest of the train, and the frame count never grows outside a train. The serial line is also checked on every cycle: it stays silent during a train or when nothing is stored, and the completion pulse is one cycle long and directly follows a valid bit. The bench scenarios are needed to show that the serial stream has the right content. That means the marker, the stamp and the per-channel code placement, the oldest-first order, and the truncation at DEPTH frames. They also show that a new train discards a half-read store. The bench sweeps every trigger pattern of a four-channel build to cover these.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    localparam int unsigned HFS_NCH_DEF   = 64;
    localparam int unsigned HFS_TS_W_DEF  = 24;
    localparam int unsigned HFS_HDR_W_DEF = 8;
    localparam int unsigned HFS_DEPTH_DEF = 128;
    localparam logic [7:0]  HFS_MARK_DEF  = 8'hA5;
endpackage

// File: rtl/hfs_frame_mem.sv
module hfs_frame_mem #(
    parameter int unsigned FW    = 160,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [FW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [FW-1:0] rdata
);
    logic [FW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/hfs_serializer.sv
module hfs_serializer #(
    parameter int unsigned FW    = 160,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned BW   = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          train_active,
    input  logic          shift_tick,
    input  logic [CW-1:0] count,
    input  logic [FW-1:0] frame,
    output logic [AW-1:0] rd_ptr,
    output logic          ser_out,
    output logic          ser_valid,
    output logic          drain,
    output logic          done
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [BW-1:0] bitc;
        logic          sout;
        logic          svalid;
        logic          fin;
        logic          done;
    } ser_s;

    ser_s ser_d, ser_q;
    logic [BW-1:0] idx;

    assign idx = BW'(FW - 1) - ser_q.bitc;

    always_comb begin
        ser_d        = ser_q;
        ser_d.svalid = 1'b0;
        ser_d.done   = 1'b0;
        if (train_active) begin
            ser_d.rd   = '0;
            ser_d.bitc = '0;
            ser_d.fin  = 1'b0;
        end else if (ser_q.fin) begin
            ser_d.done = 1'b1;
            ser_d.fin  = 1'b0;
            ser_d.rd   = '0;
            ser_d.bitc = '0;
        end else if (count != '0 && shift_tick) begin
            ser_d.sout   = frame[idx];
            ser_d.svalid = 1'b1;
            if (ser_q.bitc == BW'(FW - 1)) begin
                ser_d.bitc = '0;
                if (CW'(ser_q.rd) + CW'(1) == count) ser_d.fin = 1'b1;
                else                                  ser_d.rd  = ser_q.rd + 1'b1;
            end else begin
                ser_d.bitc = ser_q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign rd_ptr    = ser_q.rd;
    assign ser_out   = ser_q.sout;
    assign ser_valid = ser_q.svalid;
    assign drain     = ser_q.fin;
    assign done      = ser_q.done;

    AST_QUIET_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        train_active |=> !ser_valid); // R10
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !train_active) |=> !ser_valid); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ser_valid)); // R7
endmodule

// File: rtl/hit_frame_store.sv
module hit_frame_store
    import hfs_pkg::*;
#(
    parameter int unsigned NCH      = HFS_NCH_DEF,
    parameter int unsigned TS_W     = HFS_TS_W_DEF,
    parameter int unsigned HDR_W    = HFS_HDR_W_DEF,
    parameter int unsigned DEPTH    = HFS_DEPTH_DEF,
    parameter logic [HDR_W-1:0] HDR_MARK = HDR_W'(HFS_MARK_DEF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           train_active,
    input  logic           bunch_tick,
    input  logic [NCH-1:0] trig_lo,
    input  logic [NCH-1:0] trig_hi,
    input  logic           shift_tick,
    output logic           ser_out,
    output logic           ser_valid,
    output logic           readout_done,
    output logic           mem_full
);
    localparam int unsigned FW = 2 * NCH + TS_W + HDR_W;
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0]   count;
        logic [TS_W-1:0] bcid;
        logic            train;
    } acq_s;

    acq_s acq_d, acq_q;

    logic [2*NCH-1:0] codes;
    logic             any_hit;
    logic             start;
    logic [CW-1:0]    base_count;
    logic             we;
    logic [AW-1:0]    waddr;
    logic [FW-1:0]    wdata;
    logic [FW-1:0]    rdata;
    logic [AW-1:0]    raddr;
    logic             drain;

    for (genvar c = 0; c < NCH; c++) begin : g_code
        assign codes[2*c+1] = trig_hi[c];
        assign codes[2*c]   = trig_lo[c];
    end

    assign any_hit    = |codes;
    assign start      = train_active && !acq_q.train;
    assign base_count = start ? '0 : acq_q.count;
    assign wdata      = {HDR_MARK, acq_q.bcid, codes};

    always_comb begin
        acq_d       = acq_q;
        acq_d.train = train_active;
        we          = 1'b0;
        waddr       = base_count[AW-1:0];
        if (start || drain) acq_d.count = '0;
        if (!train_active) begin
            acq_d.bcid = '0;
        end else if (bunch_tick) begin
            acq_d.bcid = acq_q.bcid + 1'b1;
            if (any_hit && base_count != CW'(DEPTH)) begin
                we          = 1'b1;
                acq_d.count = base_count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acq_q <= '0;
        else        acq_q <= acq_d;
    end

    assign mem_full = (acq_q.count == CW'(DEPTH));

    hfs_frame_mem #(.FW(FW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    hfs_serializer #(.FW(FW), .DEPTH(DEPTH)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .train_active (train_active),
        .shift_tick   (shift_tick),
        .count        (acq_q.count),
        .frame        (rdata),
        .rd_ptr       (raddr),
        .ser_out      (ser_out),
        .ser_valid    (ser_valid),
        .drain        (drain),
        .done         (readout_done)
    );

    AST_BCID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (train_active && acq_q.train && bunch_tick) |=> (acq_q.bcid == TS_W'($past(acq_q.bcid) + 1'b1))); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full && train_active && acq_q.train) |=> mem_full); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acq_q.count <= CW'(DEPTH)); // R4
    AST_NO_GROWTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!train_active && !drain) |=> (acq_q.count == $past(acq_q.count))); // R2
endmodule

// File: tb/sim_hit_frame_store.sv
`timescale 1ns/1ps
module sim_hit_frame_store;
    localparam int NCH   = 4;
    localparam int DEPTH = 8;
    localparam int TS_W  = 24;
    localparam int FW    = 2 * NCH + TS_W + 8;
    localparam logic [7:0] MARK = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_active = 1'b0, bunch_tick = 1'b0, shift_tick = 1'b0;
    logic [NCH-1:0] trig_lo = '0, trig_hi = '0;
    logic ser_out, ser_valid, readout_done, mem_full;

    int checks = 0, fails = 0;
    int done_cnt = 0;
    int bcid_m = 0;
    logic prev_valid = 1'b0;
    logic [FW-1:0] exp_q[$];
    logic got_bits[$];

    always #2.5 clk = ~clk;

    hit_frame_store #(.NCH(NCH), .TS_W(TS_W), .HDR_W(8), .DEPTH(DEPTH), .HDR_MARK(MARK)) u0 (
        .clk(clk), .rst_n(rst_n), .train_active(train_active), .bunch_tick(bunch_tick),
        .trig_lo(trig_lo), .trig_hi(trig_hi), .shift_tick(shift_tick),
        .ser_out(ser_out), .ser_valid(ser_valid), .readout_done(readout_done), .mem_full(mem_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_valid) got_bits.push_back(ser_out);
            if (readout_done) begin
                done_cnt++;
                chk(prev_valid == 1'b1, "R7 done follows last bit", 64'(prev_valid), 64'd1);
            end
            prev_valid = ser_valid;
        end
    end

    function automatic logic [2*NCH-1:0] pack(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
        logic [2*NCH-1:0] f;
        for (int c = 0; c < NCH; c++) begin
            f[2*c+1] = b[c];
            f[2*c]   = a[c];
        end
        return f;
    endfunction

    task automatic begin_train();
        train_active = 1'b1; bunch_tick = 1'b0; trig_lo = '0; trig_hi = '0;
        bcid_m = 0;
        exp_q.delete();
        got_bits.delete();
        @(negedge clk);
    endtask

    // one bunch tick (R1, R2), then a gap cycle with triggers but no tick (R2)
    task automatic acq(input logic [NCH-1:0] a, input logic [NCH-1:0] b, input bit gap);
        trig_lo = a; trig_hi = b; bunch_tick = 1'b1;
        @(negedge clk);
        if ((|{a, b}) && exp_q.size() < DEPTH)
            exp_q.push_back({MARK, TS_W'(bcid_m), pack(a, b)});
        bcid_m++;
        bunch_tick = 1'b0;
        if (gap) begin
            trig_lo = ~a; trig_hi = b ^ 4'h5;
            @(negedge clk);
        end
    endtask

    task automatic readout(input string tag);
        int d0;
        logic [FW-1:0] got;
        train_active = 1'b0; bunch_tick = 1'b0; trig_lo = '0; trig_hi = '0;
        d0 = done_cnt;
        for (int i = 0; i < FW * DEPTH * 2 + 40; i++) begin
            shift_tick = (i % 2 == 0);
            @(negedge clk);
            if (done_cnt != d0) break;
        end
        shift_tick = 1'b0;
        if (exp_q.size() != 0)
            chk(mem_full == 1'b0, "R7 store empty at done", 64'(mem_full), 64'd0);
        for (int i = 0; i < 6; i++) begin
            shift_tick = 1'b1;
            @(negedge clk);
        end
        shift_tick = 1'b0;
        chk(done_cnt == d0 + (exp_q.size() != 0 ? 1 : 0), {"R7 R8 done count ", tag},
            64'(done_cnt - d0), 64'(exp_q.size() != 0 ? 1 : 0));
        chk(got_bits.size() == FW * exp_q.size(), {"R5 R6 bit count ", tag},
            64'(got_bits.size()), 64'(FW * exp_q.size()));
        if (got_bits.size() == FW * exp_q.size()) begin
            for (int f = 0; f < exp_q.size(); f++) begin
                got = '0;
                for (int j = 0; j < FW; j++) got = {got[FW-2:0], got_bits[f*FW + j]};
                chk(got == exp_q[f], {"R3 R5 R6 frame ", tag}, 64'(got), 64'(exp_q[f]));
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_valid == 1'b0, "reset ser_valid", 64'(ser_valid), 64'd0);
        chk(readout_done == 1'b0, "reset readout_done", 64'(readout_done), 64'd0);
        chk(mem_full == 1'b0, "reset mem_full", 64'(mem_full), 64'd0);

        // R8: empty store, including ticks without triggers (R2)
        begin_train();
        for (int i = 0; i < 5; i++) acq('0, '0, 1'b0);
        readout("R8 empty");

        // R2 R3 R5 R6: exhaustive sweep of every 8-bit trigger pattern
        for (int p = 0; p < 256; p += 8) begin
            begin_train();
            for (int k = 0; k < 8; k++) acq(NCH'(p + k), NCH'((p + k) >> 4), 1'b1);
            readout("sweep");
        end

        // R1 R4: long train, sparse hits, overfill past DEPTH
        begin_train();
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 0) acq(4'h9, 4'h2, 1'b0);
            else             acq('0, '0, 1'b0);
        end
        chk(mem_full == 1'b1, "R4 full after DEPTH frames", 64'(mem_full), 64'd1);
        chk(exp_q.size() == DEPTH, "R4 model depth", 64'(exp_q.size()), 64'(DEPTH));
        readout("R1 R4 long train");

        // R9 R10: partial readout, then a new train with shift strobes held high
        begin_train();
        for (int i = 0; i < 3; i++) acq(4'hF, 4'h0, 1'b0);
        train_active = 1'b0;
        begin
            int d0;
            d0 = done_cnt;
            for (int i = 0; i < 30; i++) begin
                shift_tick = (i % 2 == 0);
                @(negedge clk);
            end
            chk(done_cnt == d0, "R9 no done on partial readout", 64'(done_cnt - d0), 64'd0);
        end
        shift_tick = 1'b1;
        begin_train();
        acq(4'h1, 4'h8, 1'b1);
        acq('0, '0, 1'b1);
        acq(4'h6, 4'h6, 1'b1);
        chk(got_bits.size() == 0, "R10 no bits during train", 64'(got_bits.size()), 64'd0);
        shift_tick = 1'b0;
        readout("R9 restart");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule